// File: doc/BRIEF.md
# Binary-Tree Serial-to-Parallel Converter

This block turns a serial bit stream, one bit per clock, into 8-bit parallel words. The stream enters at the root of a binary tree three levels deep. Every node takes one input stream and deals it into two output streams at half its input rate. The eight leaf streams of the last level are the bits of the word. All nodes run from the single bit clock. The slower node rates come from clock enables, which a phase counter decodes as a divide-by-2, divide-by-4 and divide-by-8 schedule.

Each node has two registers. One is a capture register followed by a hold stage. The other is a plain register that samples the input half a node period later. The hold stage and the plain register load on the same enable, so both halves of a split leave the node together. The next level can then sample them as one aligned pair.

A bit-slip request stalls the whole tree and its phase counter for one bit period. The bit present in that period is discarded, and the word boundary moves by one bit. A higher layer that searches for alignment can therefore step through all eight boundaries.

Top module: `tree_deser`

## Requirements
- R1: While reset is asserted and directly after it, `wordOut` is all zeros and `wordValid` is low.
- R2: Counting bits accepted since reset from zero, word n holds accepted bits 8n to 8n+7. The earliest of these bits is on `wordOut[0]` and the latest is on `wordOut[7]`.
- R3: `wordValid` is a single-cycle pulse. Without slips, pulses come exactly 8 cycles apart. A slip inside an interval stretches it to 9 cycles.
- R4: Without a slip in between, a word is presented 10 clock edges after the edge that captured its first bit. That is the edge capturing the third bit of the next word.
- R5: After reset, `wordValid` stays low until the first complete word has passed through all three levels. The earliest pulse follows the eleventh clock edge after reset is released.
- R6: `wordOut` changes only in cycles in which `wordValid` is high.
- R7: Suppose `slipReq` is high at a clock edge and no slip is in progress. Then at the next edge nothing in the tree or the phase counter advances, and the serial bit present at that edge is discarded. All later words shift by one bit.
- R8: A request is ignored if it is high at any of the `SETTLE_CYCLES` (default 8) edges that follow an accepted request. A request held high is accepted again once that window has passed.
- R9: When the stall cycle of a slip falls on the edge that would deliver a word, that word is delivered one cycle later with its content intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Serial data bit |
| slipReq | input | 1 | Request to move the word boundary by one bit |
| wordOut | output | 8 | Deserialized word, earliest bit in bit 0 |
| wordValid | output | 1 | One-cycle strobe marking a new word on `wordOut` |

## Verification
Two functions can fall on one clock edge: the stall cycle of an accepted slip and the edge on which the last tree level would deliver a word. The bench makes this happen by sweeping a slip request across all eight counter phases. One extra case places the request exactly one phase before delivery. In every case the bench models the phase and the stall cycle itself and keeps a list of only the bits the design should keep. A deferred pulse must then arrive one cycle late, and its word must match the next eight kept bits.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  // Number of tree levels; the word width follows from it.
  localparam int TREE_DEPTH = 3;
  localparam int WORD_W     = 1 << TREE_DEPTH;

  // Phase (modulo the level period 2^(lvl+1)) at which a node of the given
  // level captures the first element of a pair into its hold register.
  function automatic int firstOff(input int lvl);
    return (2 << lvl) - 2;
  endfunction

  // Phase at which the plain register samples and the hold stage transfers,
  // half a node period after the first capture.
  function automatic int secondOff(input int lvl);
    return ((3 << lvl) - 2) % (2 << lvl);
  endfunction

  // Counter phase at which the leaf level updates the word.
  localparam int LAST_OFF = secondOff(TREE_DEPTH - 1);

  // Enables from the control to the tree, one bit per level.
  typedef struct packed {
    logic [TREE_DEPTH-1:0] enFirst;
    logic [TREE_DEPTH-1:0] enSecond;
  } dsr_strb_t;

endpackage

// File: rtl/dsr_node.sv
module dsr_node (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       enFirst,
  input  logic       enSecond,
  output logic [1:0] pair
);

  logic holdQ;

  // Capture register plus hold stage on one side, plain register on the
  // other; both outputs load on enSecond so the split pair leaves aligned.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdQ <= 1'b0;
      pair  <= 2'b00;
    end else begin
      if (enFirst) holdQ <= din;
      if (enSecond) begin
        pair[0] <= holdQ;
        pair[1] <= din;
      end
    end
  end

endmodule

// File: rtl/dsr_tree.sv
module dsr_tree
  import dsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serialIn,
  input  dsr_strb_t         strb,
  output logic [WORD_W-1:0] word
);

  // Level L carries 2^(L+1) streams; stream s holds the bits whose index
  // is congruent to s modulo 2^(L+1). Node j feeds streams j and j+2^L.
  for (genvar L = 0; L < TREE_DEPTH; L++) begin : lvl
    localparam int NN = 1 << L;
    logic [2*NN-1:0] outs;
    for (genvar j = 0; j < NN; j++) begin : nd
      logic       inBit;
      logic [1:0] pr;
      if (L == 0) begin : g_root
        assign inBit = serialIn;
      end else begin : g_inner
        assign inBit = lvl[L-1].outs[j];
      end
      dsr_node u_node (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (inBit),
        .enFirst (strb.enFirst[L]),
        .enSecond(strb.enSecond[L]),
        .pair    (pr)
      );
      assign outs[j]      = pr[0];
      assign outs[j + NN] = pr[1];
    end
  end

  assign word = lvl[TREE_DEPTH-1].outs;

endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slipReq,
  output dsr_strb_t strb,
  output logic      wordValid,
  output logic      slipHold,
  output logic      slipIdle
);

  localparam int BW = $clog2(SETTLE_CYCLES + 1);

  logic [TREE_DEPTH-1:0] phase;
  logic [BW-1:0]         busy;
  logic                  primed;
  logic                  accept;
  logic                  lastHit;

  assign slipHold = (busy == BW'(SETTLE_CYCLES));
  assign slipIdle = (busy == '0);
  assign accept   = slipReq && slipIdle;
  assign lastHit  = (phase == TREE_DEPTH'(LAST_OFF));

  // Divider schedule: each level decodes its own low counter bits.
  for (genvar L = 0; L < TREE_DEPTH; L++) begin : g_en
    assign strb.enFirst[L]  = !slipHold && (phase[L:0] == (L+1)'(firstOff(L)));
    assign strb.enSecond[L] = !slipHold && (phase[L:0] == (L+1)'(secondOff(L)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      busy      <= '0;
      primed    <= 1'b0;
      wordValid <= 1'b0;
    end else begin
      if (!slipHold) phase <= phase + 1'b1;
      if (accept) busy <= BW'(SETTLE_CYCLES);
      else if (!slipIdle) busy <= busy - 1'b1;
      if (!slipHold && lastHit) primed <= 1'b1;
      wordValid <= !slipHold && lastHit && primed;
    end
  end

endmodule

// File: rtl/tree_deser.sv
module tree_deser
  import dsr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serialIn,
  input  logic              slipReq,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);

  dsr_strb_t strb;
  logic      slipHold;
  logic      slipIdle;

  dsr_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .slipReq  (slipReq),
    .strb     (strb),
    .wordValid(wordValid),
    .slipHold (slipHold),
    .slipIdle (slipIdle)
  );

  dsr_tree u_tree (
    .clk     (clk),
    .rst_n   (rst_n),
    .serialIn(serialIn),
    .strb    (strb),
    .word    (wordOut)
  );

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker
  import dsr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slipReq,
  input logic [WORD_W-1:0] wordOut,
  input logic              wordValid,
  input logic              slipHold,
  input logic              slipIdle
);

  localparam int FIRST_EDGE = WORD_W + LAST_OFF;
  localparam int CW  = $clog2(FIRST_EDGE + 2) + 1;
  localparam int GW  = $clog2(WORD_W + 2) + 1;
  localparam int HW  = $clog2(SETTLE_CYCLES + 2) + 1;

  logic [CW-1:0] sinceRst;
  logic [GW-1:0] gap;
  logic          seenValid;
  logic [HW-1:0] holdAge;
  logic          seenHold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sinceRst  <= '0;
      gap       <= '0;
      seenValid <= 1'b0;
      holdAge   <= '0;
      seenHold  <= 1'b0;
    end else begin
      if (sinceRst != '1) sinceRst <= sinceRst + 1'b1;
      if (wordValid) begin
        gap       <= GW'(1);
        seenValid <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (slipHold) begin
        holdAge  <= HW'(1);
        seenHold <= 1'b1;
      end else if (holdAge != '1) begin
        holdAge <= holdAge + 1'b1;
      end
    end
  end

  // R3: strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wordValid |=> !wordValid);

  // R3: spacing between strobes is one word, plus one cycle at most for a slip
  a_r3_cadence: assert property (@(posedge clk) disable iff (!rst_n)
    (wordValid && seenValid) |-> (gap == GW'(WORD_W) || gap == GW'(WORD_W + 1)));

  // R5: no strobe before the pipeline has filled
  a_r5_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst <= CW'(FIRST_EDGE)) |-> !wordValid);

  // R6: the word only moves together with the strobe
  a_r6_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wordValid |-> $stable(wordOut));

  // R7: an accepted request stalls the next cycle, for one cycle only
  a_r7_slip_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (slipReq && slipIdle && !slipHold) |=> slipHold);

  a_r7_stall_once: assert property (@(posedge clk) disable iff (!rst_n)
    slipHold |=> !slipHold);

  // R8: stalls are separated by more than the settle window
  a_r8_settle_window: assert property (@(posedge clk) disable iff (!rst_n)
    (slipHold && seenHold) |-> (holdAge > HW'(SETTLE_CYCLES)));

endmodule

bind tree_deser dsr_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slipReq  (slipReq),
  .wordOut  (wordOut),
  .wordValid(wordValid),
  .slipHold (slipHold),
  .slipIdle (slipIdle)
);

// File: tb/tree_deser_bench.sv
`timescale 1ns/1ps
module tree_deser_bench;
  import dsr_pkg::*;

  localparam int W      = WORD_W;
  localparam int SETTLE = 8;
  localparam int LASTP  = ((3 << (TREE_DEPTH - 1)) - 2) % W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         serialIn = 1'b0;
  logic         slipReq = 1'b0;
  logic [W-1:0] wordOut;
  logic         wordValid;

  tree_deser #(.SETTLE_CYCLES(SETTLE)) u_tree_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .serialIn (serialIn),
    .slipReq  (slipReq),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );

  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference model state, derived from the requirements.
  int           mPhase, mBusy, accN, wp;
  bit           mPrimed;
  bit           acc[4096];
  logic [W-1:0] lastWord;
  logic [15:0]  lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mPhase = 0; mBusy = 0; accN = 0; wp = 0; mPrimed = 0; lastWord = '0;
  endtask

  function automatic bit lfBit();
    bit b = lf[0];
    lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    return b;
  endfunction

  // Drive one bit (inputs change at the falling edge), predict the next
  // rising edge, then check outputs at the following falling edge.
  task automatic step(input bit b, input bit req, input string tag);
    bit frozen, accept, expV;
    logic [W-1:0] expW;
    serialIn = b;
    slipReq  = req;
    frozen = (mBusy == SETTLE);
    accept = req && (mBusy == 0);
    expV   = 1'b0;
    if (!frozen) begin
      acc[accN] = b;
      accN++;
      if (mPhase == LASTP) begin
        expV    = mPrimed;
        mPrimed = 1'b1;
      end
      mPhase = (mPhase + 1) % W;
    end
    if (accept) mBusy = SETTLE;
    else if (mBusy > 0) mBusy--;
    @(posedge clk);
    @(negedge clk);
    chk(wordValid == expV, {tag, " R3/R4/R5 valid timing"}, 32'(wordValid), 32'(expV));
    if (wordValid && expV) begin
      for (int i = 0; i < W; i++) expW[i] = acc[wp * W + i];
      chk(wordOut == expW, {tag, " R2 word content"}, 32'(wordOut), 32'(expW));
      wp++;
      lastWord = wordOut;
    end else if (!wordValid) begin
      chk(wordOut == lastWord, {tag, " R6 word held"}, 32'(wordOut), 32'(lastWord));
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; serialIn = 1'b0; slipReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(wordOut == '0, "R1 reset word", 32'(wordOut), 32'h0);
    chk(wordValid == 1'b0, "R1 reset valid", 32'(wordValid), 32'h0);
    modelReset();
    rst_n = 1'b1;
  endtask

  initial begin
    modelReset();
    doReset();
    // Fill and constant stream
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, "R5 fill ones");
    // Alternating bits
    for (int i = 0; i < 64; i++) step(i[0], 1'b0, "R2 alternating");
    // Counting bytes: every word value k*17, bit order checked
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v = 8'(k * 17);
      for (int i = 0; i < 8; i++) step(v[i], 1'b0, "R2 counting");
    end
    // Pseudo-random stream
    for (int i = 0; i < 200; i++) step(lfBit(), 1'b0, "R4 random");
    // Slip swept across every counter phase, with an ignored second request
    for (int p = 0; p < W; p++) begin
      while (mPhase != p) step(lfBit(), 1'b0, "R7 align");
      step(lfBit(), 1'b1, "R7 slip");
      for (int i = 0; i < 3; i++) step(lfBit(), 1'b0, "R7 after slip");
      step(lfBit(), 1'b1, "R8 ignored request");
      for (int i = 0; i < 20; i++) step(lfBit(), 1'b0, "R8 after ignore");
    end
    // Stall placed exactly on the delivery edge
    while (mPhase != (LASTP + W - 1) % W) step(lfBit(), 1'b0, "R9 align");
    step(lfBit(), 1'b1, "R9 slip request");
    for (int i = 0; i < 24; i++) step(lfBit(), 1'b0, "R9 deferred word");
    // Request held high: accepted once per settle window
    for (int i = 0; i < 30; i++) step(lfBit(), 1'b1, "R8 held request");
    for (int i = 0; i < 24; i++) step(lfBit(), 1'b0, "R8 release");
    // Reset in the middle of traffic
    doReset();
    for (int i = 0; i < 40; i++) step(lfBit(), 1'b0, "R5 refill");
    chk(wp > 0, "R3 words delivered after reset", 32'(wp), 32'h1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog R1-run actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule